// File: doc/BRIEF.md
# Programmed I/O Port

This block sits between a processor-side bus and one simple external peripheral. It owns a small four-word window in the bus address space. The processor writes a data register, starts one of four command classes through a command register, and then either polls a status register or waits for an interrupt. A buffered data register lets the processor and the peripheral each run at their own rate. Only the peripheral transfer itself is paced by the peripheral's READY line.

The window can sit in the memory address space, where the ordinary read and write strobes are decoded on the address alone. It can also sit in a separate I/O space, where an extra select line must be high as well. A static mode pin chooses between the two. Commands that move data run a request/ready handshake with the peripheral. That handshake is bounded by a cycle timeout, so a peripheral that stays silent cannot hang the port.

Peripheral back-pressure rules: once `dev_req` is high, `dev_op` and `dev_wdata` stay fixed until the cycle in which `dev_ready` is also high. That cycle is the single transfer. `dev_req` drops in the next cycle. Holding `dev_ready` low stalls the port. The port abandons the request after `TIMEOUT` cycles.

Top module: `pio_port`

## Requirements
- R1: After reset, `dev_req` and `irq` are low and the status register reads 0. Status bits are busy=bit0, done=bit1, err=bit2, irq_en=bit3.
- R2: The port responds only when `bus_addr[AW-1:2]` equals `BASE[AW-1:2]`. Offset `bus_addr[1:0]` selects the register: 0 = data (read/write), 1 = status (read, and write of bit3), 2 = command (write, code in bits 1:0), 3 = unused. Reads outside the window return 0, and writes outside it change nothing.
- R3: With `mem_mapped`=1 the port decodes on the address alone. With `mem_mapped`=0 it also needs `io_sel` high, and it ignores any cycle with `io_sel` low.
- R4: Command code 3 (write) raises `dev_req` in the cycle after the command write, with `dev_op`=3 and `dev_wdata` equal to the data register. These stay unchanged until `dev_ready` is high. `dev_req` drops one cycle after that transfer.
- R5: Command code 2 (read) loads `dev_rdata` into the data register in the transfer cycle.
- R6: Command code 0 (control) runs the same handshake with `dev_op`=0 and carries the data register. It leaves the data register unchanged.
- R7: Command code 1 (test) raises no request. It loads `dev_ready` into data bit 0, with the upper bits cleared, and sets done at that same clock edge.
- R8: Busy is high while a request is outstanding, and done is set when a command completes. A status read returns the bits and then clears done and err.
- R9: `irq` is high exactly when irq_en and done are both set, so a status read lowers it.
- R10: A command written while busy is discarded and sets err. A data-register write while busy is ignored.
- R11: If `dev_ready` has not come after `TIMEOUT` cycles of `dev_req`, the request drops and both err and done are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_mapped | input | 1 | 1: memory-space decode; 0: I/O-space decode that needs io_sel |
| bus_addr | input | AW | Bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| io_sel | input | 1 | Marks an I/O-space cycle |
| bus_wdata | input | DW | Write data from the processor |
| bus_rdata | output | DW | Read data, valid in the same cycle as bus_rd |
| irq | output | 1 | Interrupt request on completion |
| dev_req | output | 1 | Request strobe to the peripheral |
| dev_op | output | 2 | Command class of the outstanding request |
| dev_wdata | output | DW | Data presented to the peripheral |
| dev_ready | input | 1 | Peripheral READY status |
| dev_rdata | input | DW | Data from the peripheral |

## Verification
On every cycle the assertions check the peripheral-side contract. A request only begins after a bus write. Its op and data hold while it stalls. It ends one cycle after a transfer. It never lasts more than `TIMEOUT` cycles. They also check that an I/O-space port drives nothing onto the read bus when the select line is low. The register-level effects can only be shown by the bench's directed scenarios. These are the contents captured by read and test commands, done and err clearing on a status read, rejection while busy, the fall of the interrupt, and the address-window limits.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    CMD_CTRL  = 2'd0,
    CMD_TEST  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } pio_cmd_e;

  localparam logic [1:0] OFF_DATA   = 2'd0;
  localparam logic [1:0] OFF_STATUS = 2'd1;
  localparam logic [1:0] OFF_CMD    = 2'd2;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_IEN  = 3;
  localparam int ST_W    = 4;
endpackage

// File: rtl/pio_decode.sv
module pio_decode #(
  parameter int          AW   = 16,
  parameter logic [AW-1:0] BASE = 16'h0040
) (
  input  logic          mem_mapped,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          io_sel,
  output logic          acc_rd,
  output logic          acc_wr,
  output logic [1:0]    acc_off
);
  logic in_window;
  logic space_ok;

  assign in_window = (bus_addr[AW-1:2] == BASE[AW-1:2]);
  assign space_ok  = mem_mapped | io_sel;
  assign acc_rd    = in_window & space_ok & bus_rd;
  assign acc_wr    = in_window & space_ok & bus_wr;
  assign acc_off   = bus_addr[1:0];
endmodule

// File: rtl/pio_handshake.sv
module pio_handshake #(
  parameter int TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] start_op,
  input  logic       dev_ready,
  output logic       dev_req,
  output logic [1:0] dev_op,
  output logic       xfer_done,
  output logic       timed_out
);
  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] LIM = TW'(TIMEOUT - 1);

  logic [TW-1:0] wait_cnt;

  assign xfer_done = dev_req & dev_ready;
  assign timed_out = dev_req & ~dev_ready & (wait_cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_req  <= 1'b0;
      dev_op   <= 2'd0;
      wait_cnt <= '0;
    end else if (start) begin
      dev_req  <= 1'b1;
      dev_op   <= start_op;
      wait_cnt <= '0;
    end else if (dev_req) begin
      if (xfer_done || timed_out) dev_req <= 1'b0;
      else                        wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [1:0]    acc_off,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          busy,
  input  logic [1:0]    cur_op,
  input  logic          xfer_done,
  input  logic          timed_out,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata,
  output logic          start,
  output logic [1:0]    start_op,
  output logic [DW-1:0] data_q,
  output logic          irq
);
  logic done_q, err_q, ien_q;
  logic data_we, stat_we, cmd_we, stat_re;
  logic [ST_W-1:0] status;
  pio_cmd_e cmd;

  assign data_we = acc_wr & (acc_off == OFF_DATA);
  assign stat_we = acc_wr & (acc_off == OFF_STATUS);
  assign cmd_we  = acc_wr & (acc_off == OFF_CMD);
  assign stat_re = acc_rd & (acc_off == OFF_STATUS);
  assign cmd     = pio_cmd_e'(bus_wdata[1:0]);

  assign start    = cmd_we & ~busy & (cmd != CMD_TEST);
  assign start_op = bus_wdata[1:0];

  always_comb begin
    status = '0;
    status[ST_BUSY] = busy;
    status[ST_DONE] = done_q;
    status[ST_ERR]  = err_q;
    status[ST_IEN]  = ien_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      case (acc_off)
        OFF_DATA:   bus_rdata = data_q;
        OFF_STATUS: bus_rdata = DW'(status);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq = ien_q & done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (stat_re) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (data_we && !busy) data_q <= bus_wdata;
      if (stat_we) ien_q <= bus_wdata[ST_IEN];
      if (cmd_we) begin
        if (busy) begin
          err_q <= 1'b1;
        end else if (cmd == CMD_TEST) begin
          data_q <= DW'(dev_ready);
          done_q <= 1'b1;
        end
      end
      if (xfer_done) begin
        done_q <= 1'b1;
        if (cur_op == CMD_READ) data_q <= dev_rdata;
      end
      if (timed_out) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int            AW      = 16,
  parameter int            DW      = 8,
  parameter logic [AW-1:0] BASE    = 16'h0040,
  parameter int            TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_mapped,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          io_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          dev_req,
  output logic [1:0]    dev_op,
  output logic [DW-1:0] dev_wdata,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata
);
  logic       acc_rd, acc_wr;
  logic [1:0] acc_off;
  logic       start, xfer_done, timed_out;
  logic [1:0] start_op;

  pio_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .mem_mapped (mem_mapped),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .io_sel     (io_sel),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_off    (acc_off)
  );

  pio_handshake #(.TIMEOUT(TIMEOUT)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_op  (start_op),
    .dev_ready (dev_ready),
    .dev_req   (dev_req),
    .dev_op    (dev_op),
    .xfer_done (xfer_done),
    .timed_out (timed_out)
  );

  pio_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_off   (acc_off),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (dev_req),
    .cur_op    (dev_op),
    .xfer_done (xfer_done),
    .timed_out (timed_out),
    .dev_ready (dev_ready),
    .dev_rdata (dev_rdata),
    .start     (start),
    .start_op  (start_op),
    .data_q    (dev_wdata),
    .irq       (irq)
  );
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int DW      = 8,
  parameter int TIMEOUT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_mapped,
  input logic          io_sel,
  input logic          bus_wr,
  input logic [DW-1:0] bus_rdata,
  input logic          dev_req,
  input logic [1:0]    dev_op,
  input logic [DW-1:0] dev_wdata,
  input logic          dev_ready
);
  localparam int CW = $clog2(TIMEOUT + 2) + 1;
  logic [CW-1:0] req_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_cycles <= '0;
    else if (dev_req) req_cycles <= req_cycles + 1'b1;
    else              req_cycles <= '0;
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !dev_ready) |=> ($stable(dev_op) && $stable(dev_wdata)));

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ready) |=> !dev_req);

  // R4
  req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req) |-> $past(bus_wr));

  // R11
  req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> (req_cycles < CW'(TIMEOUT)));

  // R3
  iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_mapped && !io_sel) |-> (bus_rdata == '0));
endmodule

bind pio_port pio_port_chk #(.DW(DW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_mapped (mem_mapped),
  .io_sel     (io_sel),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .dev_req    (dev_req),
  .dev_op     (dev_op),
  .dev_wdata  (dev_wdata),
  .dev_ready  (dev_ready)
);

// File: tb/pio_port_bench.sv
`timescale 1ns/1ps
module pio_port_bench;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [15:0] BASE = 16'h0040;
  localparam int TMO = 16;
  localparam logic [15:0] A_DATA = BASE + 16'd0;
  localparam logic [15:0] A_STAT = BASE + 16'd1;
  localparam logic [15:0] A_CMD  = BASE + 16'd2;
  localparam logic [15:0] A_FAR  = 16'h0080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_mapped = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, io_sel = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq, dev_req;
  logic [1:0] dev_op;
  logic [DW-1:0] dev_wdata;
  logic dev_ready = 1'b0;
  logic [DW-1:0] dev_rdata = '0;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pio_port #(.AW(AW), .DW(DW), .BASE(BASE), .TIMEOUT(TMO)) u_pio_port (
    .clk(clk), .rst_n(rst_n), .mem_mapped(mem_mapped), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .io_sel(io_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .dev_req(dev_req), .dev_op(dev_op),
    .dev_wdata(dev_wdata), .dev_ready(dev_ready), .dev_rdata(dev_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d, input logic io);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; io_sel = io;
    @(negedge clk);
    bus_wr = 1'b0; io_sel = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, input logic io, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; io_sel = io;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; io_sel = 1'b0;
  endtask

  task automatic pulse_ready();
    dev_ready = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 dev_req", int'(dev_req), 0);
    check("R1 irq", int'(irq), 0);
    rd_reg(A_STAT, 1'b0, v);
    check("R1 status", int'(v), 0);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    wr_reg(A_DATA, 8'hA5, 1'b0);
    rd_reg(A_DATA, 1'b0, v);
    check("R2 data readback", int'(v), 'hA5);
    wr_reg(A_FAR, 8'h3C, 1'b0);
    rd_reg(A_DATA, 1'b0, v);
    check("R2 far write ignored", int'(v), 'hA5);
    rd_reg(A_FAR, 1'b0, v);
    check("R2 far read zero", int'(v), 0);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    mem_mapped = 1'b0;
    wr_reg(A_DATA, 8'h11, 1'b0);
    rd_reg(A_DATA, 1'b1, v);
    check("R3 io_sel low write ignored", int'(v), 'hA5);
    rd_reg(A_DATA, 1'b0, v);
    check("R3 io_sel low read zero", int'(v), 0);
    wr_reg(A_DATA, 8'h22, 1'b1);
    rd_reg(A_DATA, 1'b1, v);
    check("R3 io space access", int'(v), 'h22);
    mem_mapped = 1'b1;
  endtask

  task automatic t_write();
    logic [7:0] v;
    wr_reg(A_DATA, 8'h5A, 1'b0);
    wr_reg(A_CMD, 8'd3, 1'b0);
    check("R4 req raised", int'(dev_req), 1);
    check("R4 op", int'(dev_op), 3);
    check("R4 wdata", int'(dev_wdata), 'h5A);
    rd_reg(A_STAT, 1'b0, v);
    check("R8 busy while waiting", int'(v), 'h01);
    check("R4 req held", int'(dev_req), 1);
    pulse_ready();
    check("R4 req dropped after transfer", int'(dev_req), 0);
    rd_reg(A_STAT, 1'b0, v);
    check("R8 done after write", int'(v), 'h02);
    rd_reg(A_STAT, 1'b0, v);
    check("R8 done cleared by read", int'(v), 0);
  endtask

  task automatic t_read();
    logic [7:0] v;
    dev_rdata = 8'hC3;
    wr_reg(A_CMD, 8'd2, 1'b0);
    check("R5 op", int'(dev_op), 2);
    @(negedge clk);
    pulse_ready();
    rd_reg(A_DATA, 1'b0, v);
    check("R5 captured data", int'(v), 'hC3);
    rd_reg(A_STAT, 1'b0, v);
    check("R5 done", int'(v), 'h02);
  endtask

  task automatic t_control();
    logic [7:0] v;
    wr_reg(A_DATA, 8'h77, 1'b0);
    wr_reg(A_CMD, 8'd0, 1'b0);
    check("R6 req", int'(dev_req), 1);
    check("R6 op", int'(dev_op), 0);
    check("R6 wdata", int'(dev_wdata), 'h77);
    pulse_ready();
    rd_reg(A_DATA, 1'b0, v);
    check("R6 data unchanged", int'(v), 'h77);
    rd_reg(A_STAT, 1'b0, v);
    check("R6 done", int'(v), 'h02);
  endtask

  task automatic t_test();
    logic [7:0] v;
    dev_ready = 1'b1;
    wr_reg(A_CMD, 8'd1, 1'b0);
    check("R7 no request", int'(dev_req), 0);
    dev_ready = 1'b0;
    rd_reg(A_STAT, 1'b0, v);
    check("R7 done", int'(v), 'h02);
    rd_reg(A_DATA, 1'b0, v);
    check("R7 ready sampled high", int'(v), 1);
    wr_reg(A_CMD, 8'd1, 1'b0);
    rd_reg(A_DATA, 1'b0, v);
    check("R7 ready sampled low", int'(v), 0);
    rd_reg(A_STAT, 1'b0, v);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    wr_reg(A_DATA, 8'h5A, 1'b0);
    wr_reg(A_CMD, 8'd3, 1'b0);
    wr_reg(A_CMD, 8'd2, 1'b0);
    check("R10 op kept", int'(dev_op), 3);
    wr_reg(A_DATA, 8'hFF, 1'b0);
    check("R10 wdata kept", int'(dev_wdata), 'h5A);
    rd_reg(A_STAT, 1'b0, v);
    check("R10 busy and err", int'(v), 'h05);
    pulse_ready();
    rd_reg(A_STAT, 1'b0, v);
    check("R10 done only", int'(v), 'h02);
    rd_reg(A_DATA, 1'b0, v);
    check("R10 data write ignored", int'(v), 'h5A);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr_reg(A_STAT, 8'h08, 1'b0);
    check("R9 irq idle", int'(irq), 0);
    wr_reg(A_CMD, 8'd1, 1'b0);
    check("R9 irq on done", int'(irq), 1);
    rd_reg(A_STAT, 1'b0, v);
    check("R9 status", int'(v), 'h0A);
    check("R9 irq cleared", int'(irq), 0);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    int n;
    n = 0;
    wr_reg(A_CMD, 8'd3, 1'b0);
    for (int i = 0; i < 100 && dev_req; i++) begin
      n++;
      @(negedge clk);
    end
    check("R11 request length", n, TMO);
    check("R11 irq", int'(irq), 1);
    rd_reg(A_STAT, 1'b0, v);
    check("R11 done and err", int'(v), 'h0E);
    check("R11 irq cleared", int'(irq), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_mode();
    t_write();
    t_read();
    t_control();
    t_test();
    t_busy();
    t_irq();
    t_timeout();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule